// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Sampler

This block runs next to a CPU core whose instructions take one to four clocks. It collects six interrupt sources into pending flags. Two of them are external active-low pins, sampled on every clock. The other four are internal set pulses: two timers, a serial port, and a separate SPI source with its own enable. At each instruction boundary the block decides whether the core should branch to a handler, and if so, which one.

The core marks the final clock of every instruction with `last_cyc`. It raises `one_cyc` with it when that instruction lasts a single clock. During such a final cycle the block raises a combinational `take_irq` together with a vector index. A flag only counts at a boundary if it was already latched in the cycle before the final one. For a one-clock instruction that earlier cycle is the final cycle of the instruction before it. The core later returns `irq_ack` with the index it serviced. That acknowledge clears a latched flag but does not clear a flag that follows a pin level.

Top module: `irq_boundary_unit`

## Requirements
- R1: While `rst_n` is low, and after reset is released, all flags read 0 and `take_irq` is 0.
- R2: An external pin whose mode bit is 1 (falling edge) sets its flag when one sample is 1 and the next is 0. The flag is visible on `flags_o` on the second rising edge after the pin falls. Holding the pin low does not set the flag again once it has been acknowledged.
- R3: An external pin whose mode bit is 0 (low level) makes its flag follow the inverted sampled pin, with the same two-edge delay. `irq_ack` has no effect on such a flag.
- R4: `int_set` bit 0 sets the timer-0 flag (index 1), bit 1 the timer-1 flag (index 3), bit 2 the serial flag (index 4) and bit 3 the SPI flag (index 5). Each flag is set on the edge at which its bit is high. External pin 0 maps to index 0 and pin 1 to index 2.
- R5: `irq_ack` with `ack_vec` = i clears latched flag i on the next edge. A set arriving on the same edge wins over the clear.
- R6: `take_irq` is 1 only in a cycle where `last_cyc` is 1. A pending flag gives no take in cycles where `last_cyc` is 0.
- R7: When `one_cyc` is 1, the flags that qualify are those captured in the most recent earlier cycle that had `last_cyc` high.
- R8: No take occurs while `glob_en` is 0. No take occurs for source i while `src_en[i]` is 0.
- R9: Among qualified, enabled flags the lowest index wins. `take_vec` gives that index: 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 SPI.
- R10: A flag that first becomes set in an instruction's final cycle does not qualify at that boundary. It qualifies at the next boundary, provided it is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_n | input | 2 | External interrupt pins, active low, idle high |
| ext_edge_mode | input | 2 | Per pin: 1 falling-edge, 0 low-level |
| int_set | input | 4 | Set pulses: timer0, timer1, serial, SPI |
| glob_en | input | 1 | Global interrupt enable |
| src_en | input | 6 | Per-source enable, by flag index |
| last_cyc | input | 1 | Current clock is an instruction's final cycle |
| one_cyc | input | 1 | Current instruction lasts one clock (with last_cyc) |
| irq_ack | input | 1 | Core acknowledges a serviced vector |
| ack_vec | input | 3 | Index being acknowledged |
| take_irq | output | 1 | Take an interrupt at this boundary |
| take_vec | output | 3 | Index of the chosen source |
| flags_o | output | 6 | Pending flags by index |

## Verification
The assertions assume the core respects the boundary protocol in two ways. First, `one_cyc` is only ever high together with `last_cyc`. Second, each acknowledge names the source that was just taken and arrives before the next boundary, so a flag cannot be taken twice. The directed stimulus raises `one_cyc` only in final cycles and acknowledges each take while `last_cyc` is low. It changes pin modes only while the pins are idle high, so a mode switch never leaves an edge pending.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
   localparam int NUM_SRC = 6;
   localparam int NUM_EXT = 2;
   localparam int NUM_INT = 4;
   localparam int SRC_W   = $clog2(NUM_SRC);

   // flag index order is also the priority order (lowest wins)
   typedef enum logic [SRC_W-1:0] {
      SRC_EXT0 = 3'd0,
      SRC_TMR0 = 3'd1,
      SRC_EXT1 = 3'd2,
      SRC_TMR1 = 3'd3,
      SRC_SER  = 3'd4,
      SRC_SPI  = 3'd5
   } irq_src_e;
endpackage

// File: rtl/irqb_pin_sampler.sv
module irqb_pin_sampler #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic fall_o,
   output logic low_o
);
   localparam int SH_W = STAGES + 1;

   logic [SH_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= {sh_q[SH_W-2:0], pin_n};
   end

   // newest sample at STAGES-1, the one before it at STAGES
   assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
   assign low_o  = ~sh_q[STAGES-1];
endmodule

// File: rtl/irqb_flag_bank.sv
module irqb_flag_bank
   import irqb_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] ext_fall,
   input  logic [NUM_EXT-1:0] ext_low,
   input  logic [NUM_EXT-1:0] ext_edge_mode,
   input  logic [NUM_INT-1:0] int_set,
   input  logic               ack,
   input  logic [SRC_W-1:0]   ack_idx,
   output logic [NUM_SRC-1:0] flags
);
   logic [NUM_SRC-1:0] set_vec;
   logic [NUM_SRC-1:0] lvl_sel;
   logic [NUM_SRC-1:0] lvl_val;

   always_comb begin
      set_vec = '0;
      lvl_sel = '0;
      lvl_val = '0;
      set_vec[SRC_EXT0] = ext_fall[0];
      set_vec[SRC_EXT1] = ext_fall[1];
      set_vec[SRC_TMR0] = int_set[0];
      set_vec[SRC_TMR1] = int_set[1];
      set_vec[SRC_SER]  = int_set[2];
      set_vec[SRC_SPI]  = int_set[3];
      lvl_sel[SRC_EXT0] = ~ext_edge_mode[0];
      lvl_sel[SRC_EXT1] = ~ext_edge_mode[1];
      lvl_val[SRC_EXT0] = ext_low[0];
      lvl_val[SRC_EXT1] = ext_low[1];
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
      logic clr;
      assign clr = ack && (ack_idx == SRC_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flags[i] <= 1'b0;
         else if (lvl_sel[i]) flags[i] <= lvl_val[i];
         else                 flags[i] <= set_vec[i] | (flags[i] & ~clr);
      end
   end
endmodule

// File: rtl/irqb_qualify.sv
module irqb_qualify
   import irqb_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] flags,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic               glob_en,
   input  logic               last_cyc,
   input  logic               one_cyc,
   output logic [NUM_SRC-1:0] qual
);
   logic [NUM_SRC-1:0] snap_q;
   logic [NUM_SRC-1:0] snap_last_q;
   logic [NUM_SRC-1:0] window;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q      <= '0;
         snap_last_q <= '0;
      end else begin
         snap_q <= flags;
         if (last_cyc) snap_last_q <= flags;
      end
   end

   // one-cycle instruction: use the prior instruction's final-cycle capture
   assign window = one_cyc ? snap_last_q : snap_q;
   assign qual   = window & flags & src_en & {NUM_SRC{glob_en}};
endmodule

// File: rtl/irqb_prio_pick.sv
module irqb_prio_pick #(
   parameter int N = 6,
   parameter int W = 3
) (
   input  logic [N-1:0] req,
   input  logic         last_cyc,
   output logic         take,
   output logic [W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = i[W-1:0];
      end
   end

   assign take = last_cyc & (|req);
endmodule

// File: rtl/irq_boundary_unit.sv
module irq_boundary_unit
   import irqb_pkg::*;
#(
   parameter int SYNC_STAGES = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] ext_pin_n,
   input  logic [NUM_EXT-1:0] ext_edge_mode,
   input  logic [NUM_INT-1:0] int_set,
   input  logic               glob_en,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic               last_cyc,
   input  logic               one_cyc,
   input  logic               irq_ack,
   input  logic [SRC_W-1:0]   ack_vec,
   output logic               take_irq,
   output logic [SRC_W-1:0]   take_vec,
   output logic [NUM_SRC-1:0] flags_o
);
   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_stages
      $error("SYNC_STAGES must lie in 1..4");
   end

   logic [NUM_EXT-1:0] ext_fall;
   logic [NUM_EXT-1:0] ext_low;
   logic [NUM_SRC-1:0] qual;

   for (genvar e = 0; e < NUM_EXT; e++) begin : g_pin
      irqb_pin_sampler #(.STAGES(SYNC_STAGES)) smp_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_n  (ext_pin_n[e]),
         .fall_o (ext_fall[e]),
         .low_o  (ext_low[e])
      );
   end

   irqb_flag_bank bank_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .ext_fall      (ext_fall),
      .ext_low       (ext_low),
      .ext_edge_mode (ext_edge_mode),
      .int_set       (int_set),
      .ack           (irq_ack),
      .ack_idx       (ack_vec),
      .flags         (flags_o)
   );

   irqb_qualify qual_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .flags    (flags_o),
      .src_en   (src_en),
      .glob_en  (glob_en),
      .last_cyc (last_cyc),
      .one_cyc  (one_cyc),
      .qual     (qual)
   );

   irqb_prio_pick #(.N(NUM_SRC), .W(SRC_W)) pick_i (
      .req      (qual),
      .last_cyc (last_cyc),
      .take     (take_irq),
      .idx      (take_vec)
   );
endmodule

// File: rtl/irqb_chk.sv
module irqb_chk
   import irqb_pkg::*;
(
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_EXT-1:0] ext_pin_n,
   input logic [NUM_EXT-1:0] ext_edge_mode,
   input logic [NUM_INT-1:0] int_set,
   input logic               glob_en,
   input logic [NUM_SRC-1:0] src_en,
   input logic               last_cyc,
   input logic               one_cyc,
   input logic               irq_ack,
   input logic [SRC_W-1:0]   ack_vec,
   input logic               take_irq,
   input logic [SRC_W-1:0]   take_vec,
   input logic [NUM_SRC-1:0] flags_o
);
   logic [NUM_SRC-1:0] prev_flags;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_flags <= '0;
      else        prev_flags <= flags_o;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (flags_o == '0));

   // R6
   take_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> last_cyc);

   // R8
   take_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> (glob_en && src_en[take_vec]));

   // R10
   take_prior_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> (prev_flags[take_vec] && flags_o[take_vec]));

   // R9
   take_vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> (take_vec < SRC_W'(NUM_SRC)));

   // R5
   ack_clears_tmr0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && ack_vec == SRC_TMR0 && !int_set[0]) |=> !flags_o[SRC_TMR0]);
endmodule

bind irq_boundary_unit irqb_chk chk_i (.*);

// File: tb/irq_boundary_unit_tb_top.sv
module irq_boundary_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ext_pin_n = 2'b11;
   logic [1:0] ext_edge_mode = 2'b11;
   logic [3:0] int_set = '0;
   logic       glob_en = 1'b1;
   logic [5:0] src_en = 6'h3f;
   logic       last_cyc = 1'b0;
   logic       one_cyc = 1'b0;
   logic       irq_ack = 1'b0;
   logic [2:0] ack_vec = '0;
   logic       take_irq;
   logic [2:0] take_vec;
   logic [5:0] flags_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   irq_boundary_unit dut_i (.*);

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic do_ack(input logic [2:0] v);
      irq_ack = 1'b1; ack_vec = v;
      cyc();
      irq_ack = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      int_set = 4'hf; ext_pin_n = 2'b00;
      repeat (3) cyc();
      #1 chk("R1 flags in reset", flags_o, 0);
      chk("R1 take in reset", take_irq, 0);
      int_set = 0; ext_pin_n = 2'b11;
      cyc(); rst_n = 1'b1;
      repeat (3) cyc();
      #1 chk("R1 flags after reset", flags_o, 0);
      chk("R1 take after reset", take_irq, 0);
   endtask

   task automatic t_edge();
      cyc(); ext_pin_n[0] = 1'b0;
      cyc(); #1 chk("R2 not yet after one edge", flags_o[0], 0);
      cyc(); #1 chk("R2 set after second edge", flags_o[0], 1);
      do_ack(3'd0);
      chk("R5 ack clears ext0", flags_o[0], 0);
      repeat (3) cyc();
      #1 chk("R2 held low no re-set", flags_o[0], 0);
      ext_pin_n[0] = 1'b1;
      repeat (3) cyc();
   endtask

   task automatic t_level();
      ext_edge_mode[1] = 1'b0;
      cyc(); ext_pin_n[1] = 1'b0;
      cyc(); cyc(); #1 chk("R3 level flag follows pin", flags_o[2], 1);
      do_ack(3'd2);
      chk("R3 ack ignored on level flag", flags_o[2], 1);
      ext_pin_n[1] = 1'b1;
      cyc(); cyc(); #1 chk("R3 level flag drops with pin", flags_o[2], 0);
      ext_edge_mode[1] = 1'b1;
      cyc();
   endtask

   task automatic t_pulse();
      int_set = 4'hf;
      cyc(); int_set = 0;
      #1 chk("R4 internal set mapping", flags_o, 6'b111010);
      do_ack(3'd1); do_ack(3'd3); do_ack(3'd4); do_ack(3'd5);
      chk("R5 all acked", flags_o, 0);
      int_set = 4'b0001; irq_ack = 1'b1; ack_vec = 3'd1;
      cyc(); int_set = 0; irq_ack = 1'b0;
      #1 chk("R5 set wins over ack", flags_o[1], 1);
      do_ack(3'd1);
      chk("R5 cleared afterward", flags_o[1], 0);
   endtask

   task automatic t_window();
      int_set = 4'b0010;
      cyc(); int_set = 0; last_cyc = 1'b1;
      #1 chk("R10 fresh flag not taken", take_irq, 0);
      chk("R10 flag is pending", flags_o[3], 1);
      cyc(); #1 chk("R6 take at next boundary", take_irq, 1);
      chk("R9 vector timer1", take_vec, 3);
      last_cyc = 1'b0;
      #1 chk("R6 no take mid instruction", take_irq, 0);
      cyc(); #1 chk("R6 still none mid instruction", take_irq, 0);
      do_ack(3'd3);
   endtask

   task automatic t_one();
      int_set = 4'b0100;
      cyc(); int_set = 0; last_cyc = 1'b1; one_cyc = 1'b1;
      #1 chk("R7 one-cycle fresh flag not taken", take_irq, 0);
      cyc(); #1 chk("R7 one-cycle takes prior capture", take_irq, 1);
      chk("R7 vector serial", take_vec, 4);
      last_cyc = 1'b0; one_cyc = 1'b0;
      do_ack(3'd4);
   endtask

   task automatic t_prio();
      ext_pin_n[0] = 1'b0; int_set = 4'b1101;
      cyc(); int_set = 0;
      cyc(); cyc();
      last_cyc = 1'b1;
      #1 chk("R9 ext0 first", take_vec, 0);
      chk("R9 take", take_irq, 1);
      last_cyc = 1'b0; do_ack(3'd0);
      last_cyc = 1'b1;
      #1 chk("R9 timer0 next", take_vec, 1);
      last_cyc = 1'b0; do_ack(3'd1);
      last_cyc = 1'b1;
      #1 chk("R9 serial next", take_vec, 4);
      src_en[4] = 1'b0;
      #1 chk("R8 serial disabled gives spi", take_vec, 5);
      glob_en = 1'b0;
      #1 chk("R8 global off no take", take_irq, 0);
      glob_en = 1'b1; src_en[5] = 1'b0;
      #1 chk("R8 all pending disabled", take_irq, 0);
      last_cyc = 1'b0; src_en = 6'h3f;
      do_ack(3'd4); do_ack(3'd5);
      chk("R5 all clear at end", flags_o, 0);
      ext_pin_n[0] = 1'b1;
   endtask

   initial begin
      t_reset();
      t_edge();
      t_level();
      t_pulse();
      t_window();
      t_one();
      t_prio();
      repeat (2) cyc();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule